// File: doc/BRIEF.md
# Rolling Activation Window Limiter

This block bounds the number of row-activate commands a single rank receives within any sliding span of `WINDOW_CYC` clock cycles. The command scheduler raises `act_i` for one cycle each time it issues an activate. The limiter stores the cycle numbers of the most recent `MAX_ACTS` activates in a circular buffer. It grants `act_ok_o` while fewer than `MAX_ACTS` of them remain inside the window. The scheduler must only issue an activate in a cycle where `act_ok_o` is high.

The buffer always points at its oldest entry. A new activate is granted when that entry is empty or at least `WINDOW_CYC` cycles old. After reset every entry is empty, so the first `MAX_ACTS` activates pass at once. An activate issued while the grant is low is reported on `act_err_o` one cycle later. It is still recorded as the newest entry, because the command did reach the device. With `WINDOW_CYC` set to 0 the limiter is built without storage, holds the grant high and never reports an error.

The typical setting is 4 activates in 32 cycles, which is a 40 ns window at 800 MHz. A stricter setting is 2 activates in a longer window.

Top module: `act_window_limiter`

## Requirements
- R1: Out of reset, `act_ok_o` is 1 and `act_err_o` is 0.
- R2: Starting from reset, `MAX_ACTS` activates on consecutive cycles are all granted (`act_ok_o` = 1 in each cycle in which `act_i` is high).
- R3: An activate sampled on the clock edge where the cycle count is t is stamped t. Once `MAX_ACTS` activates are stored, `act_ok_o` is 0 until the cycle whose count is (oldest stamp + `WINDOW_CYC`). In that cycle it returns to 1. The grant only falls in the cycle right after an activate.
- R4: The limit slides. Each new activate replaces the oldest stamp, so the next grant is set by the next-oldest of the last `MAX_ACTS` activates.
- R5: An activate sampled while `act_ok_o` = 0 drives `act_err_o` = 1 for exactly the following cycle. In every other case `act_err_o` = 0. The offending activate is stored as the newest stamp.
- R6: With `WINDOW_CYC` = 0, `act_ok_o` is always 1 and `act_err_o` is always 0, whatever arrives on `act_i`.
- R7: With `MAX_ACTS` = 2, a third activate is held off until the first one is `WINDOW_CYC` cycles old.
- R8: Activates spaced at least `WINDOW_CYC` cycles apart are never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | One-cycle strobe: a row activate was issued this cycle |
| act_ok_o | output | 1 | A row activate may be issued this cycle |
| act_err_o | output | 1 | The previous cycle's activate broke the window limit |

## Verification
The assertions check on every cycle that the error flag follows exactly the activates sampled while the grant was low. They also check that the grant only falls right after an activate, that the disabled variant keeps the grant high with no error, and that the grant is high in the first cycle after reset. The bench's scenarios are needed to show the exact cycle in which the grant returns: at the oldest stamp plus the window, as the window slides across bursts, sparse traffic and random traffic. They also cover the two-activate and disabled configurations, which run side by side on the same stimulus.

// File: rtl/act_lim_pkg.sv
package act_lim_pkg;
  // counter width: modulus must exceed the window so elapsed 0..WINDOW is exact
  function automatic int stamp_width(input int window_cyc);
    int w;
    w = 1;
    while ((1 << w) <= window_cyc) w++;
    return w;
  endfunction

  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/act_lim_ctr.sv
module act_lim_ctr #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] now_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_o <= '0;
    else         now_o <= now_o + 1'b1;
  end
endmodule

// File: rtl/act_lim_slot.sv
module act_lim_slot #(
  parameter int CW         = 6,
  parameter int WINDOW_CYC = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] now_i,
  input  logic          wr_i,
  output logic          busy_o,
  output logic          aged_o
);
  logic [CW-1:0] stamp_q;
  logic [CW-1:0] elapsed;

  // modular difference is exact because a slot is freed when elapsed reaches the window
  assign elapsed = now_i - stamp_q;
  assign aged_o  = elapsed >= CW'(WINDOW_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      stamp_q <= '0;
    end else if (wr_i) begin
      busy_o  <= 1'b1;
      stamp_q <= now_i;
    end else if (busy_o && aged_o) begin
      busy_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/act_lim_pick.sv
module act_lim_pick #(
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic [DEPTH-1:0] busy_i,
  input  logic [DEPTH-1:0] aged_i,
  input  logic [PW-1:0]    oldest_i,
  output logic             ok_o
);
  always_comb begin
    ok_o = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (PW'(i) == oldest_i) ok_o = !busy_i[i] || aged_i[i];
    end
  end
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter
  import act_lim_pkg::*;
#(
  parameter int MAX_ACTS   = 4,
  parameter int WINDOW_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic act_ok_o,
  output logic act_err_o
);
  localparam int CW = stamp_width(WINDOW_CYC);
  localparam int PW = ptr_width(MAX_ACTS);

  generate
    if (WINDOW_CYC == 0) begin : g_off
      assign act_ok_o  = 1'b1;
      assign act_err_o = 1'b0;
    end else begin : g_on
      logic [CW-1:0]       now;
      logic [PW-1:0]       oldest_q;
      logic [MAX_ACTS-1:0] busy, aged, wr;
      logic                ok;
      logic                err_q;

      act_lim_ctr #(.CW(CW)) u_ctr (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .now_o (now)
      );

      for (genvar s = 0; s < MAX_ACTS; s++) begin : g_slot
        assign wr[s] = act_i && (oldest_q == PW'(s));
        act_lim_slot #(.CW(CW), .WINDOW_CYC(WINDOW_CYC)) u_slot (
          .clk_i (clk_i),
          .rst_ni(rst_ni),
          .now_i (now),
          .wr_i  (wr[s]),
          .busy_o(busy[s]),
          .aged_o(aged[s])
        );
      end

      act_lim_pick #(.DEPTH(MAX_ACTS), .PW(PW)) u_pick (
        .busy_i  (busy),
        .aged_i  (aged),
        .oldest_i(oldest_q),
        .ok_o    (ok)
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          oldest_q <= '0;
          err_q    <= 1'b0;
        end else begin
          err_q <= act_i && !ok;
          if (act_i) begin
            if (oldest_q == PW'(MAX_ACTS - 1)) oldest_q <= '0;
            else                               oldest_q <= oldest_q + 1'b1;
          end
        end
      end

      assign act_ok_o  = ok;
      assign act_err_o = err_q;
    end
  endgenerate
endmodule

// File: rtl/act_window_limiter_chk.sv
module act_window_limiter_chk #(
  parameter int MAX_ACTS   = 4,
  parameter int WINDOW_CYC = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic act_i,
  input logic act_ok_o,
  input logic act_err_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R1
  first_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> (act_ok_o && !act_err_o));

  // R5
  err_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (act_err_o == $past(act_i && !act_ok_o)));

  // R3
  drop_after_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $fell(act_ok_o)) |-> $past(act_i));

  // R6
  off_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WINDOW_CYC == 0) |-> (act_ok_o && !act_err_o));

  // R5
  err_needs_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_err_o |-> $past(act_i));
endmodule

bind act_window_limiter act_window_limiter_chk #(
  .MAX_ACTS  (MAX_ACTS),
  .WINDOW_CYC(WINDOW_CYC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .act_i    (act_i),
  .act_ok_o (act_ok_o),
  .act_err_o(act_err_o)
);

// File: tb/sim_act_window_limiter.sv
`timescale 1ns/100ps
module sim_act_window_limiter;
  localparam int NCFG = 3;
  localparam int N_C[NCFG] = '{4, 2, 4};
  localparam int W_C[NCFG] = '{32, 40, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic act = 1'b0;
  logic [NCFG-1:0] ok, err;

  always #2.5 clk = ~clk;

  act_window_limiter #(.MAX_ACTS(4), .WINDOW_CYC(32)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .act_i(act), .act_ok_o(ok[0]), .act_err_o(err[0]));
  act_window_limiter #(.MAX_ACTS(2), .WINDOW_CYC(40)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .act_i(act), .act_ok_o(ok[1]), .act_err_o(err[1]));
  act_window_limiter #(.MAX_ACTS(4), .WINDOW_CYC(0)) u2 (
    .clk_i(clk), .rst_ni(rst_ni), .act_i(act), .act_ok_o(ok[2]), .act_err_o(err[2]));

  typedef struct { logic [NCFG-1:0] ok; logic [NCFG-1:0] err; string req; } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  longint now = 0;
  longint hist[NCFG][$];
  logic [NCFG-1:0] viol_prev = '0;
  string cur_req = "R1";
  bit done = 0;

  function automatic logic model_ok(int c);
    if (W_C[c] == 0) return 1'b1;
    if (hist[c].size() < N_C[c]) return 1'b1;
    return (now - hist[c][0]) >= W_C[c];
  endfunction

  // driver: one cycle of stimulus, pushes the expectation for this cycle
  task automatic step(input logic a);
    exp_t e;
    @(negedge clk);
    #1;
    act = a;
    for (int c = 0; c < NCFG; c++) begin
      e.ok[c]  = model_ok(c);
      e.err[c] = viol_prev[c];
    end
    e.req = (W_C[0] == 0) ? "R6" : cur_req;
    sb.push_back(e);
    @(posedge clk);
    for (int c = 0; c < NCFG; c++) begin
      viol_prev[c] = a && !e.ok[c] && (W_C[c] != 0);
      if (a && W_C[c] != 0) begin
        hist[c].push_back(now);
        if (hist[c].size() > N_C[c]) void'(hist[c].pop_front());
      end
    end
    now++;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        string r;
        e = sb.pop_front();
        for (int c = 0; c < NCFG; c++) begin
          r = (c == 2) ? "R6" : (c == 1 && e.req != "R1") ? "R7" : e.req;
          checks++;
          if (ok[c] !== e.ok[c]) begin
            fails++;
            $display("FAIL %s u%0d act_ok_o t=%0d got %b exp %b", r, c, now, ok[c], e.ok[c]);
          end
          checks++;
          if (err[c] !== e.err[c]) begin
            fails++;
            $display("FAIL %s u%0d act_err_o t=%0d got %b exp %b", (c == 2) ? "R6" : "R5",
                     c, now, err[c], e.err[c]);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R1: reset state
    cur_req = "R1";
    step(0); step(0);
    // R2: burst from empty history
    cur_req = "R2";
    for (int i = 0; i < 4; i++) step(1);
    // R3: blocked until the oldest stamp ages by the window
    cur_req = "R3";
    for (int i = 0; i < 40; i++) step(0);
    // R5: violation while blocked
    cur_req = "R5";
    for (int i = 0; i < 4; i++) step(1);
    step(1); step(0); step(1); step(0);
    for (int i = 0; i < 45; i++) step(0);
    // R4: sliding window with spaced activates
    cur_req = "R4";
    for (int k = 0; k < 6; k++) begin
      step(1);
      for (int i = 0; i < 9; i++) step(0);
    end
    for (int i = 0; i < 45; i++) step(0);
    // R8: sparse traffic never blocked
    cur_req = "R8";
    for (int k = 0; k < 6; k++) begin
      step(1);
      for (int i = 0; i < 40; i++) step(0);
    end
    // R3: random traffic, honoring the grant most of the time
    cur_req = "R3";
    for (int i = 0; i < 600; i++) begin
      logic a;
      a = ($urandom_range(0, 3) == 0);
      if (a && !model_ok(0) && $urandom_range(0, 7) != 0) a = 1'b0;
      step(a);
    end
    step(0); step(0);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule